// File: doc/BRIEF.md
# Multi-mode ADC measurement scheduler

This block drives one multiplexed voltage converter in a monitor for a stack of up to seven series cells. For every slot it chooses the mux input and the conversion setting, issues a one-cycle start, and then holds until the converter answers with a done pulse. Three schedules share the converter. The continuous run loop measures every configured cell and then one shared slot. The shared slot rotates through five slower quantities, one per loop. The sleep schedule stays quiet until an interval tick arrives and then measures everything in one burst. The boot schedule is a burst with fixed oversampling and runs after reset or whenever the block leaves halt.

In the run loop, a 2-bit throttle can add a contiguous stretch of idle time after each loop to save power. Mode changes take effect only at the boundary of a loop or burst. Leaving sleep always passes through one full burst before the run loop starts. The block reports completed loops, completed shared rotations and completed boot bursts as single-cycle pulses.

Top module: `meas_sched`

## Requirements
- R1: While `rst` is high, every output is 0. After `rst` falls with `mode_i` = 00 (halt), no start is issued.
- R2: When `mode_i` leaves halt (00 or 11) for run (01) or sleep (10), a boot burst runs. It converts cells 1..N (mux codes 0..N-1) and then mux codes 7 (TS), 8 (internal temperature), 9 (stack), 10 (REG18) and 11 (VSS). Its setting code is 5 (OSR 384) for codes 7 and 8 and 4 (OSR 96) for every other slot. At the end `init_done_o` pulses once, and `loop_done_o` and `full_done_o` do not.
- R3: A run loop converts cells 1..N with setting code `cell_wid_i` and then one shared slot with setting code `aux_wid_i`, for N+1 slots.
- R4: The shared slot takes mux codes 7, 8, 9, 10, 11 on successive loops and then wraps. `full_done_o` pulses together with `loop_done_o` on the loop whose shared slot was 11. The rotation restarts at 7 each time the run loop is entered.
- R5: With throttle setting s = `slow_i`, the gap from a `loop_done_o` pulse to the next start is 1 + (2^s − 1)·(N+1)·BASE_CYC·2^`cell_wid_i` cycles.
- R6: In sleep, no start is issued until `nap_tick_i` is seen. The tick then launches a burst of N+5 slots with the R2 mux order, using `cell_wid_i` for cells and `aux_wid_i` otherwise. At the end of the burst `loop_done_o` and `full_done_o` pulse together.
- R7: Switching to run while the block waits in sleep starts one full burst and then the run loop. Switching to run while a burst is in progress lets that burst finish, and the run loop follows with no second burst.
- R8: After the loop in progress ends, halt mode issues no starts. A later return to run or sleep begins with a new boot burst.
- R9: `cell_cnt_i` (1..7) is captured when each loop or burst begins. A change during a loop affects only later loops.
- R10: `adc_start_o` lasts one cycle. No new start is issued before `adc_done_i` answers the previous one, and `mux_sel_o` and `conv_cfg_o` hold until then.
- R11: The throttle has no effect on bursts. After a burst, the next start follows its completion pulse by one cycle, whatever `slow_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 00/11 halt, 01 run, 10 sleep |
| cell_cnt_i | input | 3 | Number of series cells in use, 1..7 |
| cell_wid_i | input | 2 | Slot-width code for cell slots (0..3) |
| aux_wid_i | input | 2 | Slot-width code for non-cell slots (0..3) |
| slow_i | input | 2 | Throttle: 0, 1, 3 or 7 idle slots per active slot |
| nap_tick_i | input | 1 | Sleep interval expiry tick |
| adc_done_i | input | 1 | Conversion finished |
| adc_start_o | output | 1 | One-cycle conversion start |
| mux_sel_o | output | 4 | Input select: cells 0..6, then 7..11 for TS, internal temperature, stack, REG18, VSS |
| conv_cfg_o | output | 3 | 0..3 slot-width code, 4 = OSR 96, 5 = OSR 384 |
| loop_done_o | output | 1 | Pulse at the end of a run loop or sleep burst |
| full_done_o | output | 1 | Pulse at the end of a shared rotation or sleep burst |
| init_done_o | output | 1 | Pulse at the end of a boot burst |

## Verification
The delicate collision is a request to leave sleep that lands while a sleep burst is already converting. Exit handling and burst completion then fall into the same window, and a careless scheduler would either cut the burst short or run a second one. The bench raises the interval tick, waits for the first start of the burst, and switches the mode to run in the very next cycle. It then compares the logged slot sequence with one complete burst followed directly by a run loop whose shared slot is TS. A second case sends the exit request while the block is idle in sleep and checks that exactly one burst precedes the loop.

// File: rtl/sched_pkg.sv
package sched_pkg;
  // mode codes on mode_i
  localparam logic [1:0] MD_RUN = 2'b01;
  localparam logic [1:0] MD_NAP = 2'b10;

  // non-cell measurements, in slot order after the cells
  localparam int EXTRAS   = 5;
  localparam int EX_TS    = 0;
  localparam int EX_ITEMP = 1;

  // conversion setting codes beyond the four slot widths
  localparam logic [2:0] CFG_OSR96  = 3'd4;
  localparam logic [2:0] CFG_OSR384 = 3'd5;

  typedef enum logic [1:0] {K_BOOT, K_BURST, K_LOOP} kind_t;
  typedef enum logic [2:0] {S_HALT, S_WAIT, S_LAUNCH, S_BUSY, S_IDLE} st_t;
endpackage

// File: rtl/sched_slot_map.sv
module sched_slot_map
  import sched_pkg::*;
#(
  parameter int MAX_CELLS = 7,
  parameter int CW = 3,
  parameter int SW = 4,
  parameter int RW = 3
) (
  input  kind_t         kind_i,
  input  logic [SW-1:0] sidx_i,
  input  logic [CW-1:0] ncell_i,
  input  logic [RW-1:0] rot_i,
  input  logic [1:0]    cell_wid_i,
  input  logic [1:0]    aux_wid_i,
  output logic [SW-1:0] sel_o,
  output logic [2:0]    cfg_o,
  output logic          last_o
);
  logic          is_cell;
  logic [SW-1:0] ex;
  logic [SW-1:0] len;

  always_comb begin
    is_cell = sidx_i < SW'(ncell_i);
    ex      = (kind_i == K_LOOP) ? SW'(rot_i) : sidx_i - SW'(ncell_i);
    sel_o   = is_cell ? sidx_i : SW'(MAX_CELLS) + ex;
    if (kind_i == K_BOOT)
      cfg_o = (!is_cell && (ex == SW'(EX_TS) || ex == SW'(EX_ITEMP))) ? CFG_OSR384 : CFG_OSR96;
    else
      cfg_o = is_cell ? {1'b0, cell_wid_i} : {1'b0, aux_wid_i};
    len    = SW'(ncell_i) + ((kind_i == K_LOOP) ? SW'(1) : SW'(EXTRAS));
    last_o = (sidx_i == len - SW'(1));
  end
endmodule

// File: rtl/sched_idle_timer.sv
module sched_idle_timer #(
  parameter int MAX_CELLS = 7,
  parameter int BASE_CYC = 4,
  parameter int CW = 3,
  localparam int MAXV = 7 * (MAX_CELLS + 1) * BASE_CYC * 8,
  localparam int TW = $clog2(MAXV + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [1:0]    slow_i,
  input  logic [CW-1:0] ncell_i,
  input  logic [1:0]    wid_i,
  output logic          fin_o
);
  logic [TW-1:0] cnt_q;
  int            load_val;

  always_comb
    load_val = ((1 << slow_i) - 1) * (int'(ncell_i) + 1) * (BASE_CYC << wid_i);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (load_i) cnt_q <= TW'(load_val);
    else if (cnt_q != '0) cnt_q <= cnt_q - TW'(1);
  end

  assign fin_o = (cnt_q == TW'(1));

  // R5
  idle_countdown_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - TW'(1)));
endmodule

// File: rtl/meas_sched.sv
module meas_sched
  import sched_pkg::*;
#(
  parameter int MAX_CELLS = 7,
  parameter int BASE_CYC = 4,
  localparam int CW = $clog2(MAX_CELLS + 1),
  localparam int SW = $clog2(MAX_CELLS + EXTRAS),
  localparam int RW = $clog2(EXTRAS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode_i,
  input  logic [CW-1:0] cell_cnt_i,
  input  logic [1:0]    cell_wid_i,
  input  logic [1:0]    aux_wid_i,
  input  logic [1:0]    slow_i,
  input  logic          nap_tick_i,
  input  logic          adc_done_i,
  output logic          adc_start_o,
  output logic [SW-1:0] mux_sel_o,
  output logic [2:0]    conv_cfg_o,
  output logic          loop_done_o,
  output logic          full_done_o,
  output logic          init_done_o
);
  st_t           st;
  kind_t         kind;
  logic [SW-1:0] sidx;
  logic [CW-1:0] ncell;
  logic [RW-1:0] rot;
  logic [CW-1:0] cnt_clamp;
  logic [SW-1:0] map_sel;
  logic [2:0]    map_cfg;
  logic          map_last;
  logic          run, nap, tmr_load, tmr_fin;
  st_t           bnd_st;

  assign run = (mode_i == MD_RUN);
  assign nap = (mode_i == MD_NAP);

  always_comb begin
    if (cell_cnt_i == '0) cnt_clamp = CW'(1);
    else if (int'(cell_cnt_i) > MAX_CELLS) cnt_clamp = CW'(MAX_CELLS);
    else cnt_clamp = cell_cnt_i;
    bnd_st = run ? S_LAUNCH : (nap ? S_WAIT : S_HALT);
  end

  assign tmr_load = (st == S_BUSY) && adc_done_i && map_last &&
                    (kind == K_LOOP) && (slow_i != 2'b00);

  sched_slot_map #(.MAX_CELLS(MAX_CELLS), .CW(CW), .SW(SW), .RW(RW)) u_map (
    .kind_i(kind), .sidx_i(sidx), .ncell_i(ncell), .rot_i(rot),
    .cell_wid_i(cell_wid_i), .aux_wid_i(aux_wid_i),
    .sel_o(map_sel), .cfg_o(map_cfg), .last_o(map_last));

  sched_idle_timer #(.MAX_CELLS(MAX_CELLS), .BASE_CYC(BASE_CYC), .CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .load_i(tmr_load), .slow_i(slow_i),
    .ncell_i(ncell), .wid_i(cell_wid_i), .fin_o(tmr_fin));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_HALT; kind <= K_BOOT; sidx <= '0; ncell <= CW'(1); rot <= '0;
      adc_start_o <= 1'b0; mux_sel_o <= '0; conv_cfg_o <= '0;
      loop_done_o <= 1'b0; full_done_o <= 1'b0; init_done_o <= 1'b0;
    end else begin
      adc_start_o <= 1'b0;
      loop_done_o <= 1'b0;
      full_done_o <= 1'b0;
      init_done_o <= 1'b0;
      case (st)
        S_HALT: if (run || nap) begin
          st <= S_LAUNCH; kind <= K_BOOT; sidx <= '0; ncell <= cnt_clamp;
        end
        S_WAIT: begin
          if (run || (nap && nap_tick_i)) begin
            st <= S_LAUNCH; kind <= K_BURST; sidx <= '0; ncell <= cnt_clamp;
          end else if (!nap) st <= S_HALT;
        end
        S_LAUNCH: begin
          adc_start_o <= 1'b1;
          mux_sel_o   <= map_sel;
          conv_cfg_o  <= map_cfg;
          st          <= S_BUSY;
        end
        S_BUSY: if (adc_done_i) begin
          if (!map_last) begin
            sidx <= sidx + SW'(1);
            st   <= S_LAUNCH;
          end else begin
            if (kind == K_LOOP) begin
              loop_done_o <= 1'b1;
              full_done_o <= (rot == RW'(EXTRAS - 1));
              rot <= (rot == RW'(EXTRAS - 1)) ? '0 : rot + RW'(1);
            end else begin
              rot <= '0;
              if (kind == K_BOOT) init_done_o <= 1'b1;
              else begin loop_done_o <= 1'b1; full_done_o <= 1'b1; end
            end
            if (tmr_load) st <= S_IDLE;
            else begin
              st <= bnd_st; kind <= K_LOOP; sidx <= '0; ncell <= cnt_clamp;
            end
          end
        end
        S_IDLE: if (tmr_fin) begin
          st <= bnd_st; kind <= K_LOOP; sidx <= '0; ncell <= cnt_clamp;
        end
        default: st <= S_HALT;
      endcase
    end
  end

  // R10
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    adc_start_o |=> !adc_start_o);
  // R10
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_BUSY && !adc_done_i) |=> ($stable(mux_sel_o) && $stable(conv_cfg_o)));
  // R6
  full_with_loop_chk: assert property (@(posedge clk) disable iff (rst)
    full_done_o |-> loop_done_o);
  // R2
  init_alone_chk: assert property (@(posedge clk) disable iff (rst)
    init_done_o |-> (!loop_done_o && !full_done_o));
  // R2
  osr384_target_chk: assert property (@(posedge clk) disable iff (rst)
    (adc_start_o && conv_cfg_o == CFG_OSR384) |->
      (mux_sel_o == SW'(MAX_CELLS + EX_TS) || mux_sel_o == SW'(MAX_CELLS + EX_ITEMP)));
  // R6
  nap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT && nap && !nap_tick_i) |=> (st == S_WAIT));
endmodule

// File: tb/meas_sched_bench.sv
module meas_sched_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic [2:0] cnt = 3'd3;
  logic [1:0] cw = 2'd0, ow = 2'd0, slow = 2'd0;
  logic tick = 1'b0, done = 1'b0;
  logic start, loop_p, full_p, init_p;
  logic [3:0] sel;
  logic [2:0] cfg;

  int nchk = 0, nfail = 0;
  int logn = 0, n_loop = 0, n_full = 0, n_init = 0, full_at = 0;
  int lsel [0:1023];
  int lcfg [0:1023];
  int lat = 0, viol = 0, cyc = 0, loop_cyc = 0, last_gap = -1;
  bit prev_start = 0, gap_pend = 0, finished = 0;

  always #5 clk = ~clk;

  meas_sched u_meas_sched (
    .clk(clk), .rst(rst), .mode_i(mode), .cell_cnt_i(cnt), .cell_wid_i(cw),
    .aux_wid_i(ow), .slow_i(slow), .nap_tick_i(tick), .adc_done_i(done),
    .adc_start_o(start), .mux_sel_o(sel), .conv_cfg_o(cfg),
    .loop_done_o(loop_p), .full_done_o(full_p), .init_done_o(init_p));

  // converter model and activity log, sampled on the falling edge
  initial forever begin
    @(negedge clk);
    cyc++;
    done = 1'b0;
    if (rst) begin
      lat = 0; prev_start = 0;
    end else begin
      if (start) begin
        if (lat != 0 || prev_start) viol++;
        lsel[logn] = int'(sel); lcfg[logn] = int'(cfg); logn++;
        if (gap_pend) begin last_gap = cyc - loop_cyc; gap_pend = 0; end
      end
      if (lat != 0) begin lat--; if (lat == 0) done = 1'b1; end
      if (start) lat = 3;
      prev_start = start;
      if (init_p) n_init++;
      if (loop_p) begin n_loop++; loop_cyc = cyc; gap_pend = 1; end
      if (full_p) begin n_full++; if (n_full == 1) full_at = n_loop; end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int n, input int c, input int o, input int s);
    @(negedge clk);
    rst = 1'b1; mode = 2'b00; tick = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 start in reset", int'(start), 0);
    chk("R1 pulses in reset", int'(loop_p | full_p | init_p), 0);
    chk("R1 sel/cfg in reset", int'(sel) + int'(cfg), 0);
    logn = 0; n_loop = 0; n_full = 0; n_init = 0; full_at = 0; last_gap = -1; gap_pend = 0;
    cnt = 3'(n); cw = 2'(c); ow = 2'(o); slow = 2'(s);
    rst = 1'b0;
  endtask

  task automatic t_boot_and_run();
    do_reset(3, 1, 2, 0);
    repeat (20) @(negedge clk);
    chk("R1 halt after reset, no start", logn, 0);
    mode = 2'b01;
    wait (n_init == 1);
    chk("R2 boot slot count", logn, 8);
    chk("R2 no loop pulse in boot", n_loop, 0);
    for (int i = 0; i < 8; i++) begin
      chk("R2 boot mux order", lsel[i], (i < 3) ? i : 7 + (i - 3));
      chk("R2 boot osr code", lcfg[i], (i == 3 || i == 4) ? 5 : 4);
    end
    wait (n_loop == 6);
    for (int j = 0; j < 6; j++)
      for (int k = 0; k < 4; k++) begin
        chk("R3 loop mux", lsel[8 + 4*j + k], (k < 3) ? k : 7 + (j % 5));
        chk("R3 loop width code", lcfg[8 + 4*j + k], (k < 3) ? 1 : 2);
      end
    chk("R4 full pulses after 6 loops", n_full, 1);
    chk("R4 full pulse on 5th loop", full_at, 5);
    chk("R5 gap with no throttle", last_gap, 1);
  endtask

  task automatic t_throttle();
    do_reset(2, 1, 0, 2);
    mode = 2'b01;
    wait (n_loop == 2);
    wait (logn == 14);
    chk("R5 idle gap slow=2 N=2 wid=1", last_gap, 73);
    slow = 2'd1;
    wait (n_loop == 3);
    wait (logn == 17);
    chk("R5 idle gap slow=1 N=2 wid=1", last_gap, 1 + 1*3*4*2);
  endtask

  task automatic t_sleep();
    do_reset(2, 0, 3, 3);
    mode = 2'b10;
    wait (n_init == 1);
    repeat (40) @(negedge clk);
    chk("R6 no start before tick", logn, 7);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    wait (n_loop == 1);
    chk("R6 burst slot count", logn, 14);
    chk("R6 full pulse at burst end", n_full, 1);
    for (int i = 0; i < 7; i++) begin
      chk("R6 burst mux order", lsel[7 + i], (i < 2) ? i : 7 + (i - 2));
      chk("R6 burst width code", lcfg[7 + i], (i < 2) ? 0 : 3);
    end
    repeat (30) @(negedge clk);
    chk("R6 quiet after burst", logn, 14);
    mode = 2'b01;
    wait (n_loop == 2);
    wait (logn == 22);
    chk("R11 no idle after burst despite slow=3", last_gap, 1);
    wait (n_loop == 3);
    for (int i = 0; i < 7; i++)
      chk("R7 exit burst from wait", lsel[14 + i], (i < 2) ? i : 7 + (i - 2));
    chk("R7 loop after exit burst, cell1", lsel[21], 0);
    chk("R7 loop after exit burst, TS", lsel[23], 7);
    chk("R7 full pulses", n_full, 2);
  endtask

  task automatic t_exit_mid_burst();
    int base, l0;
    do_reset(3, 0, 0, 0);
    mode = 2'b01;
    wait (n_loop == 6);
    mode = 2'b10;
    repeat (60) @(negedge clk);
    base = logn;
    repeat (30) @(negedge clk);
    chk("R6 wait holds after run->sleep", logn, base);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    wait (logn == base + 1);
    mode = 2'b01;
    l0 = n_loop;
    wait (n_loop == l0 + 2);
    for (int i = 0; i < 8; i++)
      chk("R7 running burst completes", lsel[base + i], (i < 3) ? i : 7 + (i - 3));
    for (int k = 0; k < 4; k++)
      chk("R4 rotation restarts at TS", lsel[base + 8 + k], (k < 3) ? k : 7);
  endtask

  task automatic t_halt();
    int base;
    do_reset(2, 0, 0, 0);
    mode = 2'b01;
    wait (n_loop == 2);
    mode = 2'b11;
    repeat (60) @(negedge clk);
    base = logn;
    repeat (40) @(negedge clk);
    chk("R8 no start in halt", logn, base);
    mode = 2'b01;
    wait (n_init == 2);
    chk("R8 reboot slot count", logn - base, 7);
    chk("R8 reboot TS osr384", lcfg[base + 2], 5);
    chk("R8 reboot stack osr96", lcfg[base + 4], 4);
  endtask

  task automatic t_count_change();
    int l;
    do_reset(3, 0, 0, 0);
    mode = 2'b01;
    wait (n_loop == 1);
    l = logn;
    wait (logn == l + 1);
    cnt = 3'd1;
    wait (n_loop == 3);
    chk("R9 current loop keeps 3 cells", lsel[l + 2], 2);
    chk("R9 current loop shared", lsel[l + 3], 8);
    chk("R9 next loop one cell", lsel[l + 4], 0);
    chk("R9 next loop shared", lsel[l + 5], 9);
    chk("R9 slots after change", logn, l + 6);
    chk("R10 handshake violations", viol, 0);
  endtask

  initial begin
    t_boot_and_run();
    t_throttle();
    t_sleep();
    t_exit_mid_burst();
    t_halt();
    t_count_change();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule